// File: doc/BRIEF.md
# Two-Capacitor Submodule Gate Mapper

This block turns a per-capacitor insertion request into the six gate commands of one converter submodule that holds two capacitors. The request carries one bit per capacitor. The number of set bits gives the output level: zero, one capacitor voltage or two capacitor voltages. When exactly one bit is set, that bit also picks which capacitor is inserted, so the middle level has two redundant switch states. The zero level closes both bypass legs in parallel, so the arm current is shared between them.

A three-bit fault code selects a restricted state table for a missing capacitor, open switches or a lost bypass leg. A request that the active table cannot honour is replaced by the nearest allowed state, and a sticky flag records the event. The sign of the arm current breaks the tie when two allowed states are equally near.

New targets are taken only on a sample strobe. A switch that turns off does so at the next clock edge. A switch that turns on waits a programmable number of extra cycles. A block command forces every gate low at the next clock edge, whatever the request or the fault code.

Top module: `sgm_gate_mapper`

## Requirements
- R1: After reset, all six gates are low and the error flag is low.
- R2: With fault code 0 (healthy), the request maps as follows. Request bit 0 stands for capacitor C1 and bit 1 for C2. Gate bit k-1 drives switch k. Request 00 turns on switches 2, 3, 5 and 6 (gates 6'b110110). Request 01 turns on switches 1 and 6 (6'b100001). Request 10 turns on switches 4 and 5 (6'b011000). Request 11 turns on switches 1 and 4 (6'b001001).
- R3: Fault code 1 means C1 is unusable. Allowed states are zero and the C2 middle state; requests 01 and 11 become the C2 middle state. Fault code 2 means C2 is unusable. Allowed states are zero and the C1 middle state; requests 10 and 11 become the C1 middle state.
- R4: Fault codes 3 (both capacitors unusable) and 7 (reserved) hold the full bypass 6'b110110 for every request.
- R5: Fault code 4 means switch 5 is open. Zero uses switches 2 and 3 only (6'b000110), the middle level uses only the C1 state, and the top level is kept. Fault code 5 means switch 6 is open. Zero is 6'b000110, the middle level uses only the C2 state, and the top level is kept.
- R6: Fault code 6 means switches 5 and 6 are both open. Only zero (6'b000110) and the top level are allowed. A middle request becomes zero when the arm current sign input is 1 (positive) and becomes the top level when it is 0.
- R7: Any request that the active fault code does not allow sets the error flag when it is strobed. The flag stays set until reset.
- R8: The gate target is updated only from inputs sampled when the strobe is high. Changes to the request or the fault code without a strobe leave the gates unchanged.
- R9: With dead-time value D, a strobe taken at edge E0 turns off the leaving gates at edge E0+1. Gates that stay on are unchanged. The arriving gates turn on at edge E0+1+D.
- R10: A block command seen at a clock edge drives all gates low at that edge. After the command is released, the gates of the held target turn on at the (D+1)th edge.
- R11: Switches 1 and 2 are never on together, and switches 3 and 4 are never on together, including while a transition is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Strobe that takes a new request and fault code |
| insReq | input | 2 | Insert request: bit 0 is C1, bit 1 is C2 |
| armCurPos | input | 1 | Arm current sign: 1 when positive |
| blockCmd | input | 1 | Converter block: forces all gates low |
| faultCode | input | 3 | Active fault case for this submodule |
| deadTime | input | DT_W | Extra cycles before a gate may turn on |
| gate | output | 6 | Gate commands; bit k-1 drives switch k |
| illegalSticky | output | 1 | Sticky flag for a coerced request |

## Verification
The dead-time property assumes that the dead-time input stays constant while a transition is under way. The bench changes it only when the gates have settled. The properties also assume that reset is held for at least one clock edge, so the first sampled history is the all-off state. The block command may arrive at any time, but the bench releases it only after the gates have been checked low. Fault codes are treated as quasi-static: each table vector is applied from a fresh reset, so no transition between fault tables takes place under a running dead-time count.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  localparam int GATE_N = 6;
  typedef logic [GATE_N-1:0] gate_t;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_NO_C1     = 3'd1,
    FLT_NO_C2     = 3'd2,
    FLT_NO_CAPS   = 3'd3,
    FLT_LEG5_OPEN = 3'd4,
    FLT_LEG6_OPEN = 3'd5,
    FLT_TWO_LEVEL = 3'd6,
    FLT_RSVD      = 3'd7
  } fault_e;

  // bit k-1 drives switch k
  localparam gate_t PAT_ZERO_BOTH = 6'b110110;
  localparam gate_t PAT_ZERO_LEG1 = 6'b000110;
  localparam gate_t PAT_MID_C1    = 6'b100001;
  localparam gate_t PAT_MID_C2    = 6'b011000;
  localparam gate_t PAT_TOP       = 6'b001001;

  typedef struct packed {
    logic loadTarget;
    logic onEnable;
    logic forceOff;
  } ctrl_strobe_t;
endpackage

// File: rtl/sgm_state_map.sv
module sgm_state_map
  import sgm_pkg::*;
(
  input  logic [1:0] insReq,
  input  logic       armCurPos,
  input  logic [2:0] faultCode,
  output gate_t      pattern,
  output logic       illegal
);
  fault_e fault;
  assign fault = fault_e'(faultCode);

  always_comb begin
    pattern = PAT_ZERO_BOTH;
    illegal = 1'b0;
    unique case (fault)
      FLT_NONE: begin
        unique case (insReq)
          2'b00: pattern = PAT_ZERO_BOTH;
          2'b01: pattern = PAT_MID_C1;
          2'b10: pattern = PAT_MID_C2;
          default: pattern = PAT_TOP;
        endcase
      end
      FLT_NO_C1: begin
        if (insReq == 2'b00) pattern = PAT_ZERO_BOTH;
        else begin
          pattern = PAT_MID_C2;
          illegal = insReq != 2'b10;
        end
      end
      FLT_NO_C2: begin
        if (insReq == 2'b00) pattern = PAT_ZERO_BOTH;
        else begin
          pattern = PAT_MID_C1;
          illegal = insReq != 2'b01;
        end
      end
      FLT_LEG5_OPEN: begin
        unique case (insReq)
          2'b00: pattern = PAT_ZERO_LEG1;
          2'b11: pattern = PAT_TOP;
          default: begin
            pattern = PAT_MID_C1;
            illegal = insReq == 2'b10;
          end
        endcase
      end
      FLT_LEG6_OPEN: begin
        unique case (insReq)
          2'b00: pattern = PAT_ZERO_LEG1;
          2'b11: pattern = PAT_TOP;
          default: begin
            pattern = PAT_MID_C2;
            illegal = insReq == 2'b01;
          end
        endcase
      end
      FLT_TWO_LEVEL: begin
        unique case (insReq)
          2'b00: pattern = PAT_ZERO_LEG1;
          2'b11: pattern = PAT_TOP;
          default: begin
            // equidistant neighbours: positive current takes the lower level
            pattern = armCurPos ? PAT_ZERO_LEG1 : PAT_TOP;
            illegal = 1'b1;
          end
        endcase
      end
      default: begin
        pattern = PAT_ZERO_BOTH;
        illegal = insReq != 2'b00;
      end
    endcase
  end
endmodule

// File: rtl/sgm_ctrl.sv
module sgm_ctrl
  import sgm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleStb,
  input  logic            blockCmd,
  input  logic            targetDiffers,
  input  logic [DT_W-1:0] deadTime,
  output ctrl_strobe_t    strb
);
  logic [DT_W-1:0] dtCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dtCnt <= '0;
    end else if (blockCmd) begin
      dtCnt <= deadTime;
    end else if (sampleStb && targetDiffers) begin
      dtCnt <= deadTime;
    end else if (dtCnt != '0) begin
      dtCnt <= dtCnt - 1'b1;
    end
  end

  always_comb begin
    strb.loadTarget = sampleStb;
    strb.onEnable   = (dtCnt == '0);
    strb.forceOff   = blockCmd;
  end
endmodule

// File: rtl/sgm_gate_path.sv
module sgm_gate_path
  import sgm_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  ctrl_strobe_t strb,
  input  gate_t        newPattern,
  input  logic         newIllegal,
  output logic         targetDiffers,
  output gate_t        gate,
  output logic         illegalSticky
);
  gate_t targetQ;
  gate_t gateQ;
  logic  errQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      targetQ <= '0;
      errQ    <= 1'b0;
    end else if (strb.loadTarget) begin
      targetQ <= newPattern;
      if (newIllegal) errQ <= 1'b1;
    end
  end

  assign targetDiffers = (newPattern != targetQ);

  for (genvar i = 0; i < GATE_N; i++) begin : g_leg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gateQ[i] <= 1'b0;
      end else if (strb.forceOff || !targetQ[i]) begin
        gateQ[i] <= 1'b0;
      end else if (strb.onEnable) begin
        gateQ[i] <= 1'b1;
      end
    end
  end

  assign gate          = gateQ;
  assign illegalSticky = errQ;
endmodule

// File: rtl/sgm_gate_mapper.sv
module sgm_gate_mapper
  import sgm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sampleStb,
  input  logic [1:0]      insReq,
  input  logic            armCurPos,
  input  logic            blockCmd,
  input  logic [2:0]      faultCode,
  input  logic [DT_W-1:0] deadTime,
  output logic [5:0]      gate,
  output logic            illegalSticky
);
  gate_t        newPattern;
  logic         newIllegal;
  logic         targetDiffers;
  ctrl_strobe_t strb;
  gate_t        gateInt;

  sgm_state_map map_i (
    .insReq    (insReq),
    .armCurPos (armCurPos),
    .faultCode (faultCode),
    .pattern   (newPattern),
    .illegal   (newIllegal)
  );

  sgm_ctrl #(.DT_W(DT_W)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sampleStb     (sampleStb),
    .blockCmd      (blockCmd),
    .targetDiffers (targetDiffers),
    .deadTime      (deadTime),
    .strb          (strb)
  );

  sgm_gate_path path_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .strb          (strb),
    .newPattern    (newPattern),
    .newIllegal    (newIllegal),
    .targetDiffers (targetDiffers),
    .gate          (gateInt),
    .illegalSticky (illegalSticky)
  );

  assign gate = gateInt;
endmodule

// File: rtl/sgm_gate_mapper_chk.sv
module sgm_gate_mapper_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            blockCmd,
  input logic [DT_W-1:0] deadTime,
  input logic [5:0]      gate,
  input logic            illegalSticky
);
  p_block_forces_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blockCmd |=> (gate == 6'b0));

  p_no_leg_short_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]));

  p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(gate) & ~gate) != 6'b0) && (deadTime != '0))
      |-> ((gate & ~$past(gate)) == 6'b0));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegalSticky |=> illegalSticky);
endmodule

bind sgm_gate_mapper sgm_gate_mapper_chk #(.DT_W(DT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .blockCmd      (blockCmd),
  .deadTime      (deadTime),
  .gate          (gate),
  .illegalSticky (illegalSticky)
);

// File: tb/sgm_gate_mapper_tb.sv
module sgm_gate_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 8;
  localparam int NVEC = 24;

  // {fault[2:0], req[1:0], curPos, expGate[5:0], expIllegal}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 1'b1, 6'h36, 1'b0},
    {3'd0, 2'b01, 1'b1, 6'h21, 1'b0},
    {3'd0, 2'b10, 1'b0, 6'h18, 1'b0},
    {3'd0, 2'b11, 1'b0, 6'h09, 1'b0},
    {3'd1, 2'b10, 1'b1, 6'h18, 1'b0},
    {3'd1, 2'b01, 1'b1, 6'h18, 1'b1},
    {3'd1, 2'b11, 1'b0, 6'h18, 1'b1},
    {3'd2, 2'b01, 1'b0, 6'h21, 1'b0},
    {3'd2, 2'b10, 1'b1, 6'h21, 1'b1},
    {3'd2, 2'b11, 1'b1, 6'h21, 1'b1},
    {3'd3, 2'b00, 1'b1, 6'h36, 1'b0},
    {3'd3, 2'b11, 1'b1, 6'h36, 1'b1},
    {3'd4, 2'b00, 1'b1, 6'h06, 1'b0},
    {3'd4, 2'b01, 1'b0, 6'h21, 1'b0},
    {3'd4, 2'b10, 1'b0, 6'h21, 1'b1},
    {3'd4, 2'b11, 1'b1, 6'h09, 1'b0},
    {3'd5, 2'b00, 1'b0, 6'h06, 1'b0},
    {3'd5, 2'b10, 1'b1, 6'h18, 1'b0},
    {3'd5, 2'b01, 1'b1, 6'h18, 1'b1},
    {3'd6, 2'b00, 1'b1, 6'h06, 1'b0},
    {3'd6, 2'b11, 1'b0, 6'h09, 1'b0},
    {3'd6, 2'b01, 1'b1, 6'h06, 1'b1},
    {3'd6, 2'b10, 1'b0, 6'h09, 1'b1},
    {3'd7, 2'b10, 1'b1, 6'h36, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sampleStb = 1'b0;
  logic [1:0]      insReq = '0;
  logic            armCurPos = 1'b0;
  logic            blockCmd = 1'b0;
  logic [2:0]      faultCode = '0;
  logic [DT_W-1:0] deadTime = '0;
  logic [5:0]      gate;
  logic            illegalSticky;

  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgm_gate_mapper #(.DT_W(DT_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sampleStb     (sampleStb),
    .insReq        (insReq),
    .armCurPos     (armCurPos),
    .blockCmd      (blockCmd),
    .faultCode     (faultCode),
    .deadTime      (deadTime),
    .gate          (gate),
    .illegalSticky (illegalSticky)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sampleStb = 1'b0;
    blockCmd = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic strobe(input logic [2:0] f, input logic [1:0] r, input logic c);
    faultCode = f;
    insReq = r;
    armCurPos = c;
    sampleStb = 1'b1;
    tick(1);
    sampleStb = 1'b0;
  endtask

  function automatic string tag_for(input logic [2:0] f);
    case (f)
      3'd0: return "R2 healthy map";
      3'd1, 3'd2: return "R3 missing capacitor";
      3'd3, 3'd7: return "R4 full bypass";
      3'd4, 3'd5: return "R5 one bypass leg open";
      default: return "R6 two-level tie break";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset gates", gate, 6'h00);
    chk("R1 reset flag", illegalSticky, 1'b0);

    // table walk, dead time zero, fresh reset for each vector
    for (int i = 0; i < NVEC; i++) begin
      deadTime = '0;
      do_reset();
      strobe(VEC[i][12:10], VEC[i][9:8], VEC[i][7]);
      tick(1);
      chk(tag_for(VEC[i][12:10]), gate, VEC[i][6:1]);
      chk("R7 flag per vector", illegalSticky, VEC[i][0]);
    end

    // R9: dead time on a partial overlap (switch 5 kept)
    do_reset();
    deadTime = '0;
    strobe(3'd0, 2'b00, 1'b1);
    tick(1);
    chk("R9 settle zero", gate, 6'h36);
    deadTime = 8'd3;
    strobe(3'd0, 2'b10, 1'b0);
    tick(1);
    chk("R9 off at once", gate, 6'h10);
    tick(2);
    chk("R9 still waiting", gate, 6'h10);
    tick(1);
    chk("R9 on after dead time", gate, 6'h18);
    strobe(3'd0, 2'b11, 1'b0);
    tick(1);
    chk("R9 keep shared switch", gate, 6'h08);
    tick(3);
    chk("R9 top reached", gate, 6'h09);

    // R8: no strobe, no change
    insReq = 2'b01;
    faultCode = 3'd5;
    tick(5);
    chk("R8 unstrobed inputs ignored", gate, 6'h09);

    // R10: block and release
    blockCmd = 1'b1;
    tick(1);
    chk("R10 block low in one clock", gate, 6'h00);
    tick(3);
    chk("R10 stays low", gate, 6'h00);
    blockCmd = 1'b0;
    tick(3);
    chk("R10 release waits dead time", gate, 6'h00);
    tick(1);
    chk("R10 release restores target", gate, 6'h09);

    // R7: sticky across a legal strobe, cleared by reset
    do_reset();
    deadTime = '0;
    strobe(3'd1, 2'b01, 1'b1);
    tick(1);
    chk("R7 flag set", illegalSticky, 1'b1);
    strobe(3'd0, 2'b00, 1'b1);
    tick(1);
    chk("R7 flag held", illegalSticky, 1'b1);
    chk("R7 legal request still mapped", gate, 6'h36);
    do_reset();
    chk("R1 R7 flag cleared by reset", illegalSticky, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule